// File: doc/BRIEF.md
# Outbound Message Descriptor Queue Controller

This block runs a circular ring of outbound message descriptors kept in a small local descriptor store. Software fills descriptor slots through a dedicated write port, then tells the controller about each new one by writing a self-clearing increment bit in the mode register. Each write of that bit moves the enqueue pointer forward by one slot. While the unit is enabled and the ring holds work, the controller presents the descriptor at the dequeue pointer on a transmit handshake. When the transmitter reports completion, the dequeue pointer moves on by one slot.

A register port gives access to four words: a mode word, a status word and two read-only pointer words. The mode word holds the enable bit, the end-of-message event enable and the ring-size field. The status word holds sticky events, which software clears by writing one to them, and a live busy bit. Each pointer word reads back as a byte address: the ring base plus 32 bytes per slot. The controller rounds each message length up to a transfer size before handing it on.

Top module: `oq_desc_queue`

## Requirements
- R1: After synchronous reset the mode word reads 0, the status word reads 0, both pointer words read RING_BASE, and tx_valid is low.
- R2: The ring-size field, mode bits [15:12] with value F, selects a ring of 2^(F+1) slots, capped at 2^MAX_LOG2 slots. Both pointers wrap from the last slot back to slot 0, which is address RING_BASE.
- R3: Register address 2 reads the dequeue pointer and address 3 reads the enqueue pointer, each as RING_BASE + 32 × slot. Writes to these two addresses have no effect.
- R4: Register address 0 is the mode word. Bit 0 is enable and bit 5 is the end-of-message event enable, and both read back. Writing 1 to bit 1 advances the enqueue pointer by one slot. Bit 1 always reads 0.
- R5: An increment while the ring already holds (size − 1) entries leaves the enqueue pointer unchanged and sets the overflow status bit, bit 5.
- R6: While the unit is enabled and the ring is non-empty, tx_valid is high and the outputs show the descriptor at the dequeue slot. A tx_done pulse while tx_valid is high completes that descriptor, and the dequeue pointer advances on that clock edge. While the unit is disabled, tx_valid is low and tx_done has no effect.
- R7: tx_size is the descriptor length rounded up to the next power of two, with a minimum of 8.
- R8: A completion with tx_err = 0 sets the end-of-message status bit, bit 1, only when mode bit 5 is set. A completion with tx_err = 1 sets the transmit-error status bit, bit 7, and never sets bit 1. In both cases the dequeue pointer advances.
- R9: The queue-full status bit, bit 4, is set when the occupancy reaches (size − 1). The queue-empty status bit, bit 0, is set when the occupancy falls from a non-zero value to 0.
- R10: Status bit 2 (busy) reads 1 exactly when the unit is enabled and the ring is non-empty. A write to the status word does not change it.
- R11: Writing the status word, address 1, clears each sticky bit written as 1 and leaves each bit written as 0 unchanged. An event in the same cycle as a clear leaves its bit set.
- R12: A descriptor write stores the destination, mailbox and length into the addressed slot. tx_dest and tx_mbox then show those values when that slot is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mode, 1 status, 2 dequeue pointer, 3 enqueue pointer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| dw_en | input | 1 | Descriptor write strobe |
| dw_slot | input | MAX_LOG2 | Descriptor slot to write |
| dw_dest | input | 16 | Destination identifier field |
| dw_mbox | input | 2 | Mailbox field |
| dw_len | input | 13 | Message length in bytes |
| tx_valid | output | 1 | A descriptor is presented to the transmitter |
| tx_dest | output | 16 | Destination of the presented descriptor |
| tx_mbox | output | 2 | Mailbox of the presented descriptor |
| tx_size | output | 14 | Rounded transfer size of the presented descriptor |
| tx_done | input | 1 | The transmitter has finished the presented descriptor |
| tx_err | input | 1 | The finished transmit failed (sampled with tx_done) |

## Verification
The hardest case to reach is the full ring. An increment arrives when (size − 1) entries are waiting, sometimes in the same cycle as a completion or a status clear. To get there from the ports, the bench runs a two-slot ring while the unit is disabled, so increments pile up with no drain. It then runs a long random phase on the largest ring, where increments, completions, transmit errors and write-one clears collide freely. A behavioural model predicts the occupancy, both pointers and every status bit for each cycle.

// File: rtl/oq_pkg.sv
package oq_pkg;
    localparam int DEST_W = 16;
    localparam int MBOX_W = 2;
    localparam int LEN_W  = 13;
    localparam int SIZE_W = 4;

    // mode word bit positions
    localparam int MD_EN       = 0;
    localparam int MD_INC      = 1;
    localparam int MD_EOMIE    = 5;
    localparam int MD_SIZE_LSB = 12;

    // status word bit positions
    localparam int ST_QE   = 0;
    localparam int ST_EOM  = 1;
    localparam int ST_BUSY = 2;
    localparam int ST_QFI  = 4;
    localparam int ST_QOI  = 5;
    localparam int ST_TE   = 7;
    localparam logic [7:0] ST_STICKY = 8'hB3;

    typedef enum logic [1:0] {
        REG_MODE = 2'd0,
        REG_STAT = 2'd1,
        REG_DEQ  = 2'd2,
        REG_ENQ  = 2'd3
    } oq_reg_e;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic [MBOX_W-1:0] mbox;
        logic [LEN_W-1:0]  len;
    } oq_desc_t;

    typedef struct packed {
        logic te;
        logic qoi;
        logic qfi;
        logic eom;
        logic qe;
    } oq_evt_t;

    // smallest power of two not below len, never under 8
    function automatic logic [LEN_W:0] round_len(input logic [LEN_W-1:0] len);
        logic [LEN_W:0] r;
        r = (LEN_W+1)'(8);
        for (int i = 0; i < LEN_W; i++)
            if (r < {1'b0, len}) r = r << 1;
        return r;
    endfunction
endpackage

// File: rtl/oq_ring_ctrl.sv
module oq_ring_ctrl
    import oq_pkg::*;
#(
    parameter int MAX_LOG2 = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SIZE_W-1:0]   size_f,
    input  logic                inc,
    input  logic                done,
    output logic [MAX_LOG2-1:0] enq_slot,
    output logic [MAX_LOG2-1:0] deq_slot,
    output logic [MAX_LOG2:0]   count,
    output logic [MAX_LOG2:0]   last,
    output logic                nonempty,
    output logic                evt_qoi,
    output logic                evt_qfi,
    output logic                evt_qe
);
    localparam int CW = MAX_LOG2 + 1;

    logic [MAX_LOG2-1:0] mask;
    logic [CW-1:0]       count_nx;
    logic                accept;

    always_comb begin
        int lg;
        lg = int'(size_f) + 1;
        if (lg > MAX_LOG2) lg = MAX_LOG2;
        last = (CW'(1) << lg) - CW'(1);
    end

    assign mask     = last[MAX_LOG2-1:0];
    assign accept   = inc && (count != last);
    assign evt_qoi  = inc && (count == last);
    assign count_nx = count + CW'(accept) - CW'(done);
    assign evt_qfi  = (count_nx == last) && (count != last);
    assign evt_qe   = (count_nx == '0) && (count != '0);
    assign nonempty = (count != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            enq_slot <= '0;
            deq_slot <= '0;
            count    <= '0;
        end else begin
            if (accept) enq_slot <= (enq_slot + 1'b1) & mask;
            if (done)   deq_slot <= (deq_slot + 1'b1) & mask;
            count <= count_nx;
        end
    end
endmodule

// File: rtl/oq_desc_store.sv
module oq_desc_store
    import oq_pkg::*;
#(
    parameter int MAX_LOG2 = 5
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic [MAX_LOG2-1:0] wr_slot,
    input  oq_desc_t            wr_desc,
    input  logic [MAX_LOG2-1:0] rd_slot,
    output oq_desc_t            rd_desc
);
    localparam int DEPTH = 1 << MAX_LOG2;

    oq_desc_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_slot] <= wr_desc;
    end

    assign rd_desc = mem[rd_slot];
endmodule

// File: rtl/oq_status.sv
module oq_status
    import oq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  oq_evt_t    evt,
    input  logic       clr_we,
    input  logic [7:0] clr_mask,
    input  logic       busy,
    output logic [7:0] status
);
    logic [7:0] sticky;
    logic [7:0] set_v;
    logic [7:0] clr_v;

    always_comb begin
        set_v         = '0;
        set_v[ST_TE]  = evt.te;
        set_v[ST_QOI] = evt.qoi;
        set_v[ST_QFI] = evt.qfi;
        set_v[ST_EOM] = evt.eom;
        set_v[ST_QE]  = evt.qe;
        clr_v         = clr_we ? (clr_mask & ST_STICKY) : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) sticky <= '0;
        else     sticky <= (sticky & ~clr_v) | set_v;
    end

    always_comb begin
        status          = sticky;
        status[ST_BUSY] = busy;
    end
endmodule

// File: rtl/oq_desc_queue.sv
module oq_desc_queue
    import oq_pkg::*;
#(
    parameter int          MAX_LOG2  = 5,
    parameter logic [31:0] RING_BASE = 32'h0001_0000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [1:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                dw_en,
    input  logic [MAX_LOG2-1:0] dw_slot,
    input  logic [DEST_W-1:0]   dw_dest,
    input  logic [MBOX_W-1:0]   dw_mbox,
    input  logic [LEN_W-1:0]    dw_len,
    output logic                tx_valid,
    output logic [DEST_W-1:0]   tx_dest,
    output logic [MBOX_W-1:0]   tx_mbox,
    output logic [LEN_W:0]      tx_size,
    input  logic                tx_done,
    input  logic                tx_err
);
    logic                en, eomie;
    logic [SIZE_W-1:0]   size_f;
    logic                mode_wr, stat_wr, inc, done;
    logic [MAX_LOG2-1:0] enq_slot, deq_slot;
    logic [MAX_LOG2:0]   count, last;
    logic                nonempty, ring_qoi, ring_qfi, ring_qe;
    logic [7:0]          status;
    oq_evt_t             evt;
    oq_desc_t            wr_desc, rd_desc;

    assign mode_wr = reg_we && (oq_reg_e'(reg_addr) == REG_MODE);
    assign stat_wr = reg_we && (oq_reg_e'(reg_addr) == REG_STAT);
    assign inc     = mode_wr && reg_wdata[MD_INC];

    always_ff @(posedge clk) begin
        if (rst) begin
            en     <= 1'b0;
            eomie  <= 1'b0;
            size_f <= '0;
        end else if (mode_wr) begin
            en     <= reg_wdata[MD_EN];
            eomie  <= reg_wdata[MD_EOMIE];
            size_f <= reg_wdata[MD_SIZE_LSB +: SIZE_W];
        end
    end

    assign tx_valid = en && nonempty;
    assign done     = tx_valid && tx_done;

    oq_ring_ctrl #(.MAX_LOG2(MAX_LOG2)) u_ring (
        .clk(clk), .rst(rst), .size_f(size_f), .inc(inc), .done(done),
        .enq_slot(enq_slot), .deq_slot(deq_slot), .count(count), .last(last),
        .nonempty(nonempty), .evt_qoi(ring_qoi), .evt_qfi(ring_qfi), .evt_qe(ring_qe)
    );

    assign wr_desc = '{dest: dw_dest, mbox: dw_mbox, len: dw_len};

    oq_desc_store #(.MAX_LOG2(MAX_LOG2)) u_store (
        .clk(clk), .wr_en(dw_en), .wr_slot(dw_slot), .wr_desc(wr_desc),
        .rd_slot(deq_slot), .rd_desc(rd_desc)
    );

    assign tx_dest = rd_desc.dest;
    assign tx_mbox = rd_desc.mbox;
    assign tx_size = round_len(rd_desc.len);

    always_comb begin
        evt.te  = done && tx_err;
        evt.eom = done && !tx_err && eomie;
        evt.qoi = ring_qoi;
        evt.qfi = ring_qfi;
        evt.qe  = ring_qe;
    end

    oq_status u_status (
        .clk(clk), .rst(rst), .evt(evt), .clr_we(stat_wr),
        .clr_mask(reg_wdata[7:0]), .busy(tx_valid), .status(status)
    );

    always_comb begin
        reg_rdata = '0;
        case (oq_reg_e'(reg_addr))
            REG_MODE: begin
                reg_rdata[MD_EN]                     = en;
                reg_rdata[MD_EOMIE]                  = eomie;
                reg_rdata[MD_SIZE_LSB +: SIZE_W]     = size_f;
            end
            REG_STAT: reg_rdata[7:0] = status;
            REG_DEQ:  reg_rdata = RING_BASE + (32'(deq_slot) << 5);
            default:  reg_rdata = RING_BASE + (32'(enq_slot) << 5);
        endcase
    end
endmodule

// File: rtl/oq_desc_queue_chk.sv
module oq_desc_queue_chk #(
    parameter int MAX_LOG2 = 5
) (
    input logic                clk,
    input logic                rst,
    input logic                tx_valid,
    input logic                tx_done,
    input logic                tx_err,
    input logic                en,
    input logic                eomie,
    input logic                inc,
    input logic [MAX_LOG2:0]   count,
    input logic [MAX_LOG2:0]   last,
    input logic [MAX_LOG2-1:0] enq_slot,
    input logic [MAX_LOG2-1:0] deq_slot,
    input logic [7:0]          status
);
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !tx_valid);

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (inc && count == last) |=> (status[5] && $stable(enq_slot)));

    p_disabled_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !en |-> !tx_valid);

    p_deq_step_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_done) |=> (deq_slot != $past(deq_slot)));

    p_eom_set_r8: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_done && !tx_err && eomie) |=> status[1]);

    p_err_set_r8: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_done && tx_err) |=> status[7]);

    p_busy_r10: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> status[2]);
endmodule

bind oq_desc_queue oq_desc_queue_chk #(.MAX_LOG2(MAX_LOG2)) u_chk (
    .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_done(tx_done), .tx_err(tx_err),
    .en(en), .eomie(eomie), .inc(inc), .count(count), .last(last),
    .enq_slot(enq_slot), .deq_slot(deq_slot), .status(status)
);

// File: tb/oq_desc_queue_test.sv
module oq_desc_queue_test;
    localparam int          MAXL  = 5;
    localparam int          DEPTH = 1 << MAXL;
    localparam logic [31:0] BASE  = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dw_en = 1'b0;
    logic [MAXL-1:0] dw_slot = '0;
    logic [15:0] dw_dest = '0;
    logic [1:0]  dw_mbox = '0;
    logic [12:0] dw_len = '0;
    logic        tx_valid;
    logic [15:0] tx_dest;
    logic [1:0]  tx_mbox;
    logic [13:0] tx_size;
    logic        tx_done = 1'b0;
    logic        tx_err = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    oq_desc_queue #(.MAX_LOG2(MAXL), .RING_BASE(BASE)) uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dw_en(dw_en),
        .dw_slot(dw_slot), .dw_dest(dw_dest), .dw_mbox(dw_mbox), .dw_len(dw_len),
        .tx_valid(tx_valid), .tx_dest(tx_dest), .tx_mbox(tx_mbox),
        .tx_size(tx_size), .tx_done(tx_done), .tx_err(tx_err)
    );

    // behavioural reference model
    int m_en, m_eomie, m_f, m_enq, m_deq, m_cnt, m_st;
    int m_dest [DEPTH];
    int m_mbox [DEPTH];
    int m_len  [DEPTH];

    function automatic int exp_size(int len);
        int p = 8;
        while (p < len) p = p * 2;
        return p;
    endfunction

    function automatic int exp_rd(int a);
        case (a)
            0: return (m_f << 12) | (m_eomie << 5) | m_en;
            1: return m_st | ((m_en != 0 && m_cnt != 0) ? 4 : 0);
            2: return int'(BASE) + m_deq * 32;
            default: return int'(BASE) + m_enq * 32;
        endcase
    endfunction

    always @(posedge clk) begin
        int lg, sz, last, ncnt, setv, clr;
        bit dn, inc, ovf, acc;
        if (rst) begin
            m_en = 0; m_eomie = 0; m_f = 0; m_enq = 0; m_deq = 0; m_cnt = 0; m_st = 0;
        end else begin
            lg = m_f + 1;
            if (lg > MAXL) lg = MAXL;
            sz = 1 << lg;
            last = sz - 1;
            dn  = (m_en != 0) && (m_cnt != 0) && tx_done;
            inc = reg_we && reg_addr == 2'd0 && reg_wdata[1];
            ovf = inc && (m_cnt == last);
            acc = inc && !ovf;
            ncnt = m_cnt + int'(acc) - int'(dn);
            setv = 0;
            if (dn && tx_err) setv |= 'h80;
            if (dn && !tx_err && m_eomie != 0) setv |= 'h02;
            if (ovf) setv |= 'h20;
            if (ncnt == last && m_cnt != last) setv |= 'h10;
            if (ncnt == 0 && m_cnt != 0) setv |= 'h01;
            clr = (reg_we && reg_addr == 2'd1) ? (int'(reg_wdata[7:0]) & 'hB3) : 0;
            m_st = ((m_st & ~clr) | setv) & 'hFF;
            if (acc) m_enq = (m_enq + 1) % sz;
            if (dn)  m_deq = (m_deq + 1) % sz;
            m_cnt = ncnt;
            if (reg_we && reg_addr == 2'd0) begin
                m_en = int'(reg_wdata[0]);
                m_eomie = int'(reg_wdata[5]);
                m_f = int'(reg_wdata[15:12]);
            end
            if (dw_en) begin
                m_dest[dw_slot] = int'(dw_dest);
                m_mbox[dw_slot] = int'(dw_mbox);
                m_len[dw_slot]  = int'(dw_len);
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // compare against the model every cycle, away from the edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            int ev;
            ev = (m_en != 0 && m_cnt != 0) ? 1 : 0;
            chk("R6 tx_valid", int'(tx_valid), ev);
            if (ev != 0) begin
                chk("R7 tx_size", int'(tx_size), exp_size(m_len[m_deq]));
                chk("R12 tx_dest", int'(tx_dest), m_dest[m_deq]);
                chk("R12 tx_mbox", int'(tx_mbox), m_mbox[m_deq]);
            end
            case (reg_addr)
                2'd0: chk("R4 mode read", int'(reg_rdata), exp_rd(0));
                2'd1: chk("R8/R9/R10/R11 status read", int'(reg_rdata), exp_rd(1));
                2'd2: chk("R3 dequeue pointer", int'(reg_rdata), exp_rd(2));
                default: chk("R3 enqueue pointer", int'(reg_rdata), exp_rd(3));
            endcase
        end
    end

    task automatic step(bit we, int a, int d, bit dn, bit er);
        @(posedge clk); #2;
        reg_we = we; reg_addr = 2'(a); reg_wdata = d;
        tx_done = dn; tx_err = er; dw_en = 1'b0;
    endtask

    task automatic dwr(int slot, int dest, int mbox, int len);
        @(posedge clk); #2;
        reg_we = 1'b0; tx_done = 1'b0; tx_err = 1'b0;
        dw_en = 1'b1; dw_slot = MAXL'(slot); dw_dest = 16'(dest);
        dw_mbox = 2'(mbox); dw_len = 13'(len);
    endtask

    task automatic look(int a);
        step(0, a, 0, 0, 0);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(posedge clk); #2;
        rst = 1'b1; reg_we = 0; dw_en = 0; tx_done = 0; tx_err = 0;
        repeat (2) @(posedge clk);
        #2 rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int lens [8] = '{1, 8, 9, 100, 4096, 2049, 17, 64};
        do_reset();
        // R1 reset values
        look(0); chk("R1 mode after reset", int'(reg_rdata), 0);
        chk("R1 tx_valid after reset", int'(tx_valid), 0);
        look(1); chk("R1 status after reset", int'(reg_rdata), 0);
        look(2); chk("R1 dequeue after reset", int'(reg_rdata), int'(BASE));
        look(3); chk("R1 enqueue after reset", int'(reg_rdata), int'(BASE));

        // two-slot ring, disabled: fill then overflow (R5, R9)
        dwr(0, 'h1111, 1, 5);
        dwr(1, 'h2222, 2, 8);
        step(1, 0, 'h0002, 0, 0);
        step(1, 0, 'h0002, 0, 0);
        look(1); chk("R5 overflow and full status", int'(reg_rdata), 'h30);
        look(3); chk("R5 enqueue held on overflow", int'(reg_rdata), int'(BASE) + 32);
        // tx_done while disabled is ignored (R6)
        step(0, 2, 0, 1, 0);
        look(2); chk("R6 done ignored while disabled", int'(reg_rdata), int'(BASE));
        // enable, send one, wrap enqueue (R2, R7)
        step(1, 0, 'h0021, 0, 0);
        look(1); chk("R7 size of 5 byte message", int'(tx_size), 8);
        step(0, 1, 0, 1, 0);
        step(1, 0, 'h0023, 0, 0);
        look(3); chk("R2 enqueue wraps to base", int'(reg_rdata), int'(BASE));
        look(2); chk("R2 dequeue on last slot", int'(reg_rdata), int'(BASE) + 32);
        step(1, 1, 'hFF, 0, 0);
        look(1); chk("R11 clear leaves busy only", int'(reg_rdata), 'h04);
        step(1, 1, 'h00, 0, 0);
        look(1); chk("R10 busy unchanged by status write", int'(reg_rdata), 'h04);

        // eight-slot ring, varied lengths (R7, R8, R12)
        do_reset();
        for (int i = 0; i < 8; i++) dwr(i, 'hA000 + i, i % 4, lens[i]);
        for (int i = 0; i < 8; i++) step(1, 0, 'h2022, 0, 0);
        look(1);
        step(1, 0, 'h2021, 0, 0);
        for (int i = 0; i < 40; i++) begin
            step((i % 5) == 0, (i % 5) == 0 ? 1 : i % 4, 'hFF, (i % 3) == 0, (i % 7) == 0);
            if ((i % 6) == 0) step(1, 0, (i % 12 == 0) ? 'h2003 : 'h2023, 0, 0);
        end

        // largest ring (size field saturates), random traffic
        do_reset();
        for (int i = 0; i < DEPTH; i++) dwr(i, $urandom & 'hFFFF, $urandom & 3, $urandom % 4097);
        for (int i = 0; i < 3000; i++) begin
            int r = int'($urandom % 16);
            bit dn = ($urandom % 3) == 0;
            bit er = ($urandom % 8) == 0;
            if (r < 6) step(1, 0, 'hF000 | (($urandom & 1) << 5) | (($urandom % 4) != 0 ? 2 : 0)
                            | (($urandom % 5) != 0 ? 1 : 0), dn, er);
            else if (r < 8) step(1, 1, $urandom & 'hFF, dn, er);
            else if (r < 10) dwr($urandom % DEPTH, $urandom & 'hFFFF, $urandom & 3, $urandom % 4097);
            else step(0, $urandom % 4, 0, dn, er);
        end
        look(1);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule